// File: doc/BRIEF.md
# Sign-extending word load unit

This unit executes the three signed 32-bit load instructions of a 64-bit big-endian processor. It accepts one 32-bit instruction word at a time and decodes it. It reads the base and index operands through two read ports into a 32-entry, 64-bit register file. It forms the effective address and issues one 4-byte read on a simple valid/ready memory port. The returned word is sign-extended to 64 bits. It finishes with a one-cycle completion pulse that carries the register-file writes.

There are three variants. The first uses a base register plus a signed 14-bit displacement scaled by four. The second uses a base register plus an index register. The third is the same as the second but also writes the computed address back into the base register. In the first two, a base field of zero stands for the value zero. The writeback variant flags the encodings the architecture declares invalid, but still carries out its writes in the defined order. Any other instruction word completes at once with a not-handled indication and has no other effect.

Top module: `sxload_unit`

## Requirements
- R1: An instruction is the displacement variant when bits 31:26 equal 58 and bits 1:0 equal 2. Bits 25:21 are the destination field, bits 20:16 the base field and bits 15:2 the displacement field. The values 0, 1 and 3 in bits 1:0 with primary 58 are not handled.
- R2: For the displacement variant, the effective address is the base value plus the displacement field with two zero bits appended and sign-extended to 64 bits. The base value is zero when the base field is 0 and the register content otherwise. The sum wraps modulo 2^64, and `mem_req_addr` carries its low 32 bits.
- R3: An instruction is the plain indexed variant when bits 31:26 equal 31 and bits 10:1 equal 341. Bits 15:11 are the index field, and bit 0 is not examined. Its address is the base value plus the index register, where the base value follows the zero rule of R2. The index field always names a register, even when it is 0.
- R4: An instruction is the indexed-with-writeback variant when bits 31:26 equal 31 and bits 10:1 equal 341+32 = 373. Its address is the base register plus the index register, and a base field of 0 reads register 0. The full 64-bit address is driven on the base write port, with `wr_base_idx` set to the base field.
- R5: The returned word has the byte at the lowest address in bits 31:24. It is sign-extended from bit 31 to 64 bits and written to the destination register through the destination write port.
- R6: The destination write and the base write occur in the same completion cycle. When both name the same register, the base write takes precedence, so the register ends up holding the effective address.
- R7: `bad_form` is high in the completion cycle exactly when the writeback variant has a base field of 0, or a base field equal to the destination field. Both writes are still performed.
- R8: An instruction matching no variant raises `done` and `unhandled` in the cycle after acceptance. It issues no memory request and asserts no write enable.
- R9: The memory request rises two cycles after acceptance. It stays valid, with its address unchanged, until the cycle in which `mem_req_ready` is high.
- R10: `done` is high for one cycle, in the cycle after the one in which `mem_rsp_valid` is high. `in_ready` is low from the cycle after acceptance through the `done` cycle, and high again in the cycle after `done`.
- R11: After reset, `in_ready` is high and `mem_req_valid`, `done`, `wr_dst_en` and `wr_base_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_insn | input | 32 | Instruction word |
| in_ready | output | 1 | Unit idle, instruction taken when valid |
| rf_a_idx | output | 5 | Base register read index |
| rf_a_data | input | 64 | Base register read data (combinational) |
| rf_b_idx | output | 5 | Index register read index |
| rf_b_data | input | 64 | Index register read data (combinational) |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read word, lowest-address byte in bits 31:24 |
| done | output | 1 | Completion pulse |
| unhandled | output | 1 | Instruction was not one of the three variants |
| bad_form | output | 1 | Invalid writeback encoding |
| wr_dst_en | output | 1 | Destination write enable |
| wr_dst_idx | output | 5 | Destination register index |
| wr_dst_data | output | 64 | Sign-extended load result |
| wr_base_en | output | 1 | Base write enable, takes precedence over destination |
| wr_base_idx | output | 5 | Base register index |
| wr_base_data | output | 64 | Effective address for base update |

## Verification
The case that is hardest to see from the ports is the writeback collision. There, base and destination name the same register, and the result depends on the order in which the register file applies two same-cycle writes. The stimulus issues such an instruction and applies the writes in the required order to the bench's register file. It then uses that register as the base of a following load, so the value it actually holds appears on the request address. The same follow-up trick shows that a normal writeback really updated the base. Zero base fields are exercised with register 0 holding a non-zero value, so that literal zero and a read of register 0 give different addresses.

// File: rtl/sxload_pkg.sv
package sxload_pkg;

    localparam int ILEN      = 32;
    localparam int XLEN      = 64;
    localparam int ALEN      = 32;
    localparam int WLEN      = 32;
    localparam int REG_COUNT = 32;
    localparam int RIDX_W    = $clog2(REG_COUNT);
    localparam int DS_W      = 14;

    localparam logic [5:0] PRIM_DISP  = 6'd58;
    localparam logic [5:0] PRIM_INDEX = 6'd31;
    localparam logic [1:0] DISP_SUB   = 2'd2;
    localparam logic [9:0] IDX_SUB    = 10'd341;
    localparam logic [9:0] IDXU_SUB   = 10'd373;

    typedef enum logic [1:0] {
        K_NONE,
        K_DISP,
        K_INDEX,
        K_INDEX_UPD
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic [RIDX_W-1:0]  dst;
        logic [RIDX_W-1:0]  base;
        logic [RIDX_W-1:0]  idx;
        logic               base_zero;
        logic               bad_form;
        logic [XLEN-1:0]    disp;
    } op_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_REQ,
        S_WAIT,
        S_FIN
    } state_e;

    function automatic logic [XLEN-1:0] widen_word(input logic [WLEN-1:0] w);
        return {{(XLEN-WLEN){w[WLEN-1]}}, w};
    endfunction

    function automatic logic [XLEN-1:0] scale_disp(input logic [DS_W-1:0] ds);
        return {{(XLEN-DS_W-2){ds[DS_W-1]}}, ds, 2'b00};
    endfunction

endpackage

// File: rtl/sxload_decode.sv
module sxload_decode
    import sxload_pkg::*;
(
    input  logic [ILEN-1:0] insn,
    output op_t             op
);
    logic [5:0] primary;
    logic [1:0] disp_sub;
    logic [9:0] idx_sub;
    logic       unused_rc;

    assign primary   = insn[31:26];
    assign disp_sub  = insn[1:0];
    assign idx_sub   = insn[10:1];
    assign unused_rc = insn[0];

    always_comb begin
        op      = '0;
        op.dst  = insn[25:21];
        op.base = insn[20:16];
        op.idx  = insn[15:11];
        op.disp = scale_disp(insn[15:2]);
        if (primary == PRIM_DISP && disp_sub == DISP_SUB)
            op.kind = K_DISP;
        else if (primary == PRIM_INDEX && idx_sub == IDX_SUB)
            op.kind = K_INDEX;
        else if (primary == PRIM_INDEX && idx_sub == IDXU_SUB)
            op.kind = K_INDEX_UPD;
        else
            op.kind = K_NONE;
        // zero base is a literal only in the forms without writeback
        op.base_zero = (op.kind == K_DISP || op.kind == K_INDEX) && (op.base == '0);
        op.bad_form  = (op.kind == K_INDEX_UPD) &&
                       ((op.base == '0) || (op.base == op.dst));
    end

endmodule

// File: rtl/sxload_agen.sv
module sxload_agen
    import sxload_pkg::*;
(
    input  logic            base_zero,
    input  logic            use_disp,
    input  logic [XLEN-1:0] disp,
    input  logic [XLEN-1:0] a_val,
    input  logic [XLEN-1:0] b_val,
    output logic [XLEN-1:0] ea
);
    logic [XLEN-1:0] base_term;
    logic [XLEN-1:0] off_term;

    always_comb begin
        base_term = base_zero ? '0 : a_val;
        off_term  = use_disp ? disp : b_val;
        ea        = base_term + off_term;
    end

endmodule

// File: rtl/sxload_seq.sv
module sxload_seq
    import sxload_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  op_t               op_in,
    output logic [RIDX_W-1:0] rd_a_idx,
    output logic [RIDX_W-1:0] rd_b_idx,
    output logic              base_zero,
    output logic              use_disp,
    output logic [XLEN-1:0]   disp,
    input  logic [XLEN-1:0]   ea_in,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ALEN-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WLEN-1:0]   mem_rsp_data,
    output logic              done,
    output logic              unhandled,
    output logic              bad_form,
    output logic              wr_dst_en,
    output logic [RIDX_W-1:0] wr_dst_idx,
    output logic [XLEN-1:0]   wr_dst_data,
    output logic              wr_base_en,
    output logic [RIDX_W-1:0] wr_base_idx,
    output logic [XLEN-1:0]   wr_base_data
);
    state_e          state_q;
    op_t             op_q;
    logic [XLEN-1:0] ea_q;
    logic [WLEN-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            op_q    <= '0;
            ea_q    <= '0;
            word_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (in_valid) begin
                    op_q    <= op_in;
                    state_q <= (op_in.kind == K_NONE) ? S_FIN : S_ADDR;
                end
                S_ADDR: begin
                    ea_q    <= ea_in;
                    state_q <= S_REQ;
                end
                S_REQ: if (mem_req_ready) state_q <= S_WAIT;
                S_WAIT: if (mem_rsp_valid) begin
                    word_q  <= mem_rsp_data;
                    state_q <= S_FIN;
                end
                S_FIN:   state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        in_ready      = (state_q == S_IDLE);
        rd_a_idx      = op_q.base;
        rd_b_idx      = op_q.idx;
        base_zero     = op_q.base_zero;
        use_disp      = (op_q.kind == K_DISP);
        disp          = op_q.disp;
        mem_req_valid = (state_q == S_REQ);
        mem_req_addr  = ea_q[ALEN-1:0];
        done          = (state_q == S_FIN);
        unhandled     = done && (op_q.kind == K_NONE);
        bad_form      = done && op_q.bad_form;
        wr_dst_en     = done && (op_q.kind != K_NONE);
        wr_dst_idx    = op_q.dst;
        wr_dst_data   = widen_word(word_q);
        wr_base_en    = done && (op_q.kind == K_INDEX_UPD);
        wr_base_idx   = op_q.base;
        wr_base_data  = ea_q;
    end

endmodule

// File: rtl/sxload_unit.sv
module sxload_unit
    import sxload_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ILEN-1:0]   in_insn,
    output logic              in_ready,
    output logic [RIDX_W-1:0] rf_a_idx,
    input  logic [XLEN-1:0]   rf_a_data,
    output logic [RIDX_W-1:0] rf_b_idx,
    input  logic [XLEN-1:0]   rf_b_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ALEN-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WLEN-1:0]   mem_rsp_data,
    output logic              done,
    output logic              unhandled,
    output logic              bad_form,
    output logic              wr_dst_en,
    output logic [RIDX_W-1:0] wr_dst_idx,
    output logic [XLEN-1:0]   wr_dst_data,
    output logic              wr_base_en,
    output logic [RIDX_W-1:0] wr_base_idx,
    output logic [XLEN-1:0]   wr_base_data
);
    op_t             dec_op;
    logic            held_base_zero;
    logic            held_use_disp;
    logic [XLEN-1:0] held_disp;
    logic [XLEN-1:0] ea_comb;

    sxload_decode dec_i (
        .insn (in_insn),
        .op   (dec_op)
    );

    sxload_agen agen_i (
        .base_zero (held_base_zero),
        .use_disp  (held_use_disp),
        .disp      (held_disp),
        .a_val     (rf_a_data),
        .b_val     (rf_b_data),
        .ea        (ea_comb)
    );

    sxload_seq seq_i (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .op_in         (dec_op),
        .rd_a_idx      (rf_a_idx),
        .rd_b_idx      (rf_b_idx),
        .base_zero     (held_base_zero),
        .use_disp      (held_use_disp),
        .disp          (held_disp),
        .ea_in         (ea_comb),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (done),
        .unhandled     (unhandled),
        .bad_form      (bad_form),
        .wr_dst_en     (wr_dst_en),
        .wr_dst_idx    (wr_dst_idx),
        .wr_dst_data   (wr_dst_data),
        .wr_base_en    (wr_base_en),
        .wr_base_idx   (wr_base_idx),
        .wr_base_data  (wr_base_data)
    );

endmodule

// File: rtl/sxload_chk.sv
module sxload_chk
    import sxload_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            in_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [ALEN-1:0] mem_req_addr,
    input logic            done,
    input logic            unhandled,
    input logic            bad_form,
    input logic            wr_dst_en,
    input logic [XLEN-1:0] wr_dst_data,
    input logic            wr_base_en
);
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    assert_busy_req_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !in_ready);

    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> !in_ready);

    assert_ready_after_done_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> in_ready && !done);

    assert_unhandled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        unhandled |-> done && !wr_dst_en && !wr_base_en && !mem_req_valid);

    assert_sign_copy_R5: assert property (@(posedge clk) disable iff (rst)
        wr_dst_en |-> wr_dst_data[XLEN-1:WLEN] == {(XLEN-WLEN){wr_dst_data[WLEN-1]}});

    assert_base_pairs_dst_R6: assert property (@(posedge clk) disable iff (rst)
        wr_base_en |-> wr_dst_en && done);

    assert_bad_writes_R7: assert property (@(posedge clk) disable iff (rst)
        bad_form |-> wr_base_en && wr_dst_en);

    assert_reset_idle_R11: assert property (@(posedge clk)
        $fell(rst) |-> in_ready && !mem_req_valid && !done && !wr_dst_en && !wr_base_en);

endmodule

bind sxload_unit sxload_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .done          (done),
    .unhandled     (unhandled),
    .bad_form      (bad_form),
    .wr_dst_en     (wr_dst_en),
    .wr_dst_data   (wr_dst_data),
    .wr_base_en    (wr_base_en)
);

// File: tb/sxload_unit_tb_top.sv
module sxload_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_insn = '0;
    logic        in_ready;
    logic [4:0]  rf_a_idx, rf_b_idx;
    logic [63:0] rf_a_data, rf_b_data;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = 32'hDEAD_BEEF;
    logic        done, unhandled, bad_form;
    logic        wr_dst_en, wr_base_en;
    logic [4:0]  wr_dst_idx, wr_base_idx;
    logic [63:0] wr_dst_data, wr_base_data;

    logic [63:0] regs [32];
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign rf_a_data = regs[rf_a_idx];
    assign rf_b_data = regs[rf_b_idx];

    sxload_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn), .in_ready(in_ready),
        .rf_a_idx(rf_a_idx), .rf_a_data(rf_a_data), .rf_b_idx(rf_b_idx), .rf_b_data(rf_b_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .unhandled(unhandled), .bad_form(bad_form),
        .wr_dst_en(wr_dst_en), .wr_dst_idx(wr_dst_idx), .wr_dst_data(wr_dst_data),
        .wr_base_en(wr_base_en), .wr_base_idx(wr_base_idx), .wr_base_data(wr_base_data)
    );

    task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] enc_disp(input int rt, input int ra, input logic [13:0] ds,
                                             input logic [1:0] sub);
        return {6'd58, 5'(rt), 5'(ra), ds, sub};
    endfunction

    function automatic logic [31:0] enc_idx(input int rt, input int ra, input int rb,
                                            input int xo, input bit rc);
        return {6'd31, 5'(rt), 5'(ra), 5'(rb), 10'(xo), rc};
    endfunction

    // 0 none, 1 displacement, 2 indexed, 3 indexed with writeback
    function automatic int variant(input logic [31:0] w);
        if (w[31:26] == 6'd58) return (w[1:0] == 2'd2) ? 1 : 0;
        if (w[31:26] == 6'd31 && w[10:1] == 10'd341) return 2;
        if (w[31:26] == 6'd31 && w[10:1] == 10'd373) return 3;
        return 0;
    endfunction

    task automatic run(input logic [31:0] w, input int rdy_wait, input int rsp_wait,
                       input logic [31:0] word, input string tag);
        int k;
        int rt, ra, rb;
        logic [63:0] base_v, off_v, ea, res;
        bit bad;
        k  = variant(w);
        rt = int'(w[25:21]);
        ra = int'(w[20:16]);
        rb = int'(w[15:11]);
        base_v = (k != 3 && ra == 0) ? 64'd0 : regs[ra];
        off_v  = (k == 1) ? 64'(longint'($signed(w[15:2])) * 4) : regs[rb];
        ea     = base_v + off_v;
        res    = 64'(longint'($signed(word)));
        bad    = (k == 3) && (ra == 0 || ra == rt);

        chk_eq({tag, " R10 ready before accept"}, 64'(in_ready), 64'd1);
        in_valid = 1'b1;
        in_insn  = w;
        step();
        in_valid = 1'b0;
        in_insn  = 32'hFFFF_FFFF;
        if (k == 0) begin
            chk_eq({tag, " R8 done"}, 64'(done), 64'd1);
            chk_eq({tag, " R8 unhandled"}, 64'(unhandled), 64'd1);
            chk_eq({tag, " R8 no writes"}, 64'({wr_dst_en, wr_base_en}), 64'd0);
            chk_eq({tag, " R8 no request"}, 64'(mem_req_valid), 64'd0);
        end else begin
            chk_eq({tag, " R9 no early request"}, 64'({mem_req_valid, done}), 64'd0);
            step();
            for (int i = 0; i < rdy_wait; i++) begin
                chk_eq({tag, " R9 request held"}, 64'(mem_req_valid), 64'd1);
                chk_eq({tag, " R9 address stable"}, 64'(mem_req_addr), 64'(ea[31:0]));
                step();
            end
            chk_eq({tag, " R9 request valid"}, 64'(mem_req_valid), 64'd1);
            chk_eq({tag, " address"}, 64'(mem_req_addr), 64'(ea[31:0]));
            mem_req_ready = 1'b1;
            step();
            mem_req_ready = 1'b0;
            for (int i = 0; i < rsp_wait; i++) begin
                chk_eq({tag, " R10 waiting"}, 64'({mem_req_valid, done}), 64'd0);
                step();
            end
            chk_eq({tag, " R10 not done before response"}, 64'(done), 64'd0);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = word;
            step();
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = ~word;
            chk_eq({tag, " R10 done"}, 64'(done), 64'd1);
            chk_eq({tag, " R8 handled"}, 64'(unhandled), 64'd0);
            chk_eq({tag, " R7 bad_form"}, 64'(bad_form), 64'(bad));
            chk_eq({tag, " R5 dst write"}, 64'({wr_dst_en, wr_dst_idx}), 64'({1'b1, 5'(rt)}));
            chk_eq({tag, " R5 dst data"}, wr_dst_data, res);
            chk_eq({tag, " R4 base enable"}, 64'(wr_base_en), 64'(k == 3));
            if (k == 3) begin
                chk_eq({tag, " R4 base idx"}, 64'(wr_base_idx), 64'(ra));
                chk_eq({tag, " R4 base data"}, wr_base_data, ea);
            end
            regs[rt] = res;
            if (k == 3) regs[ra] = ea;
        end
        step();
        chk_eq({tag, " R10 ready after done"}, 64'({in_ready, done}), 64'b10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        regs[0] = 64'h0000_0000_DEAD_0000;
        for (int i = 1; i < 32; i++) regs[i] = 64'(i) * 64'h1000;
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;
        step();
        chk_eq("R11 reset idle", 64'({in_ready, mem_req_valid, done, wr_dst_en, wr_base_en}),
               64'b10000);

        run(enc_disp(3, 5, 14'd4, 2'd2), 0, 0, 32'h8000_1234, "R1 R2 disp pos");
        run(enc_disp(4, 0, 14'h3FFD, 2'd2), 2, 3, 32'h7FFF_0001, "R2 disp zero base neg");
        run(enc_disp(4, 5, 14'd4, 2'd0), 0, 0, 32'h0, "R1 sub0");
        run(enc_disp(4, 5, 14'd4, 2'd1), 0, 0, 32'h0, "R1 sub1");
        run(enc_disp(4, 5, 14'd4, 2'd3), 0, 0, 32'h0, "R1 sub3");
        run(enc_idx(6, 7, 8, 341, 1'b0), 1, 0, 32'hFFFF_FFFF, "R3 indexed");
        run(enc_idx(9, 0, 9, 341, 1'b1), 0, 2, 32'h0000_7FFF, "R3 zero base rc");
        run(enc_idx(10, 11, 12, 373, 1'b0), 3, 1, 32'h1234_5678, "R4 writeback");
        run(enc_idx(13, 11, 0, 341, 1'b0), 0, 0, 32'hFEDC_BA98, "R4 base updated");
        run(enc_idx(14, 14, 2, 373, 1'b0), 1, 1, 32'h8765_4321, "R6 R7 same reg");
        run(enc_disp(16, 14, 14'd0, 2'd2), 0, 0, 32'h0000_0001, "R6 base wins");
        run(enc_idx(15, 0, 1, 373, 1'b0), 0, 0, 32'hC000_0000, "R4 R7 zero base");
        regs[20] = 64'hFFFF_FFFF_FFFF_FFF0;
        run(enc_disp(17, 20, 14'd8, 2'd2), 2, 0, 32'h4000_0000, "R2 wrap");
        run(enc_idx(18, 20, 21, 340, 1'b0), 0, 0, 32'h0, "R8 other xo");
        run(32'h0000_0000, 0, 0, 32'h0, "R8 zero word");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule